// File: doc/BRIEF.md
# Protection Region Slot with Process-Tag Match

This block holds one region of a memory-protection unit. Software programs it through a small register window: a lower bound, an upper bound, a word of per-master access controls, and a word carrying an 8-bit process tag, an 8-bit don't-care mask for that tag and a valid flag. A second offset in a separate part of the map reaches the access-control word alone. It lets software change permissions between tasks without disturbing validity.

For every bus access, the block takes the requesting master number, its process tag and the address. Without a clock, it reports whether the access falls inside this region. It also returns the permission field that the control word holds for that master. A larger unit instantiates one slot per region and combines the hit and permission outputs of all slots.

Register offsets are fixed by two parameters. The region index selects the four words at `DESC_BASE + 16*RGN_IDX + 4*k` (k = 0..3) and the alias word at `ALIAS_BASE + 4*RGN_IDX`. The defaults are `DESC_BASE` = 0x400 and `ALIAS_BASE` = 0x800. Reads are combinational on a separate read offset.

Top module: `mpu_region_desc`

## Requirements
- R1: While reset is held, and after it, every readable word returns zero, the valid flag is clear and `acc_hit` is 0.
- R2: A write to word 0 (lower bound) or word 1 (upper bound) stores all 32 data bits. A read at the same offset returns them.
- R3: A write to word 0, 1 or 2 clears the valid flag in the following cycle.
- R4: A write to word 3 stores the tag from data bits 31:24 and the mask from bits 23:16. It sets the valid flag to data bit 0. A read of word 3 returns the tag in bits 31:24, the mask in bits 23:16 and the valid flag in bit 0, with all other bits zero.
- R5: A write to the alias offset updates the access-control word exactly as a word 2 write would, and leaves the valid flag unchanged. A read at the alias offset returns the same value as word 2.
- R6: The access-control word keeps bits 17:0 and 29:24 as written, and reads bits 23:18 and 31:30 as zero. Master m (m = 0..2) owns bits 6m+5..6m, where bit 6m+5 is its tag-check enable. Masters 4, 5 and 6 own the 2-bit fields at bits 25:24, 27:26 and 29:28 respectively.
- R7: `acc_hit` is 1 only when the valid flag is set and lower bound <= `acc_addr` <= upper bound, with both bounds inclusive.
- R8: For masters 0..2 whose tag-check enable bit is set, a hit also requires that `(incoming_tag XOR stored_tag) AND NOT mask` is zero. A mask bit of 1 makes that bit a don't-care.
- R9: For master 0, the incoming tag is treated as zero whatever `acc_pid` carries.
- R10: Masters 3..7 never undergo the tag check. Masters 3 and 7 receive `acc_perm` = 0.
- R11: `acc_perm` returns the requesting master's 6-bit field for masters 0..2. For masters 4..6 it returns that master's 2-bit field in bits 1:0, with bits 5:2 zero.
- R12: Writes to any other offset change nothing. Reads from any other offset return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_wr | input | 1 | Register write strobe |
| cfg_woff | input | OFF_W (12) | Byte offset of the write |
| cfg_wdata | input | 32 | Write data |
| cfg_roff | input | OFF_W (12) | Byte offset of the read |
| cfg_rdata | output | 32 | Read data, combinational |
| acc_master | input | MID_W (3) | Requesting master number |
| acc_pid | input | PID_W (8) | Process tag of the access |
| acc_addr | input | ADDR_W (32) | Access address |
| acc_hit | output | 1 | Access falls inside this valid region |
| acc_perm | output | 6 | Permission field of the requesting master |

## Verification
The bench attacks both address bounds from one address below and one address above. A design that compares with strict inequalities misses hits exactly at the ends.

It exercises the valid-flag side effects word by word. A design that decodes the alias as a plain word 2 write would drop the valid flag. One that forgets to clear it on bound writes keeps hitting with stale limits.

Tag checks use partial masks, a disabled enable bit, master 0 carrying a non-zero tag, and masters 4..6. Each design error shows up on its own:
- An inverted mask rejects tags that should pass.
- A design that does not force master 0's tag to zero misses its hits.
- A design that tests the tag for masters without an enable bit loses their hits.

Writes and reads at a neighbouring region's offsets catch decoders that alias too broadly.

// File: rtl/mpu_rgn_pkg.sv
package mpu_rgn_pkg;

  typedef enum logic [2:0] {
    SEL_LO    = 3'd0,
    SEL_HI    = 3'd1,
    SEL_CTRL  = 3'd2,
    SEL_TAG   = 3'd3,
    SEL_ALIAS = 3'd4,
    SEL_NONE  = 3'd7
  } rgn_sel_e;

  localparam int unsigned DATA_W      = 32;
  localparam int unsigned PERM_W      = 6;
  localparam int unsigned NUM_FULL_M  = 3;
  localparam int unsigned FIRST_RW_M  = 4;
  localparam int unsigned NUM_RW_M    = 3;
  localparam int unsigned RW_LSB      = 24;
  localparam logic [31:0] CTRL_KEEP   = 32'h3F03_FFFF;

endpackage

// File: rtl/mpu_rgn_rst_sync.sv
module mpu_rgn_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sn
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sn = sync_q[STAGES-1];

endmodule

// File: rtl/mpu_rgn_regs.sv
module mpu_rgn_regs
  import mpu_rgn_pkg::*;
#(
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned PID_W      = 8,
  parameter int unsigned OFF_W      = 12,
  parameter int unsigned RGN_IDX    = 0,
  parameter int unsigned DESC_BASE  = 'h400,
  parameter int unsigned ALIAS_BASE = 'h800
) (
  input  logic              clk,
  input  logic              rst_sn,
  input  logic              cfg_wr,
  input  logic [OFF_W-1:0]  cfg_woff,
  input  logic [DATA_W-1:0] cfg_wdata,
  input  logic [OFF_W-1:0]  cfg_roff,
  output logic [DATA_W-1:0] cfg_rdata,
  output logic [ADDR_W-1:0] lo_q,
  output logic [ADDR_W-1:0] hi_q,
  output logic [DATA_W-1:0] ctrl_q,
  output logic [PID_W-1:0]  tag_q,
  output logic [PID_W-1:0]  mask_q,
  output logic              vld_q
);

  localparam logic [OFF_W-1:0] OFF_LO    = OFF_W'(DESC_BASE + 16 * RGN_IDX);
  localparam logic [OFF_W-1:0] OFF_HI    = OFF_W'(DESC_BASE + 16 * RGN_IDX + 4);
  localparam logic [OFF_W-1:0] OFF_CTRL  = OFF_W'(DESC_BASE + 16 * RGN_IDX + 8);
  localparam logic [OFF_W-1:0] OFF_TAG   = OFF_W'(DESC_BASE + 16 * RGN_IDX + 12);
  localparam logic [OFF_W-1:0] OFF_ALIAS = OFF_W'(ALIAS_BASE + 4 * RGN_IDX);
  localparam int unsigned      TAG_LSB   = DATA_W - 2 * PID_W;

  function automatic rgn_sel_e decode(input logic [OFF_W-1:0] off);
    if      (off == OFF_LO)    return SEL_LO;
    else if (off == OFF_HI)    return SEL_HI;
    else if (off == OFF_CTRL)  return SEL_CTRL;
    else if (off == OFF_TAG)   return SEL_TAG;
    else if (off == OFF_ALIAS) return SEL_ALIAS;
    else                       return SEL_NONE;
  endfunction

  rgn_sel_e          wsel, rsel;
  logic              reg_en;
  logic [ADDR_W-1:0] lo_d, hi_d;
  logic [DATA_W-1:0] ctrl_d;
  logic [PID_W-1:0]  tag_d, mask_d;
  logic              vld_d;

  assign wsel   = decode(cfg_woff);
  assign rsel   = decode(cfg_roff);
  assign reg_en = cfg_wr && (wsel != SEL_NONE);

  always_comb begin
    lo_d   = lo_q;
    hi_d   = hi_q;
    ctrl_d = ctrl_q;
    tag_d  = tag_q;
    mask_d = mask_q;
    vld_d  = vld_q;
    unique case (wsel)
      SEL_LO:    begin lo_d = cfg_wdata[ADDR_W-1:0]; vld_d = 1'b0; end
      SEL_HI:    begin hi_d = cfg_wdata[ADDR_W-1:0]; vld_d = 1'b0; end
      SEL_CTRL:  begin ctrl_d = cfg_wdata & CTRL_KEEP; vld_d = 1'b0; end
      SEL_ALIAS: ctrl_d = cfg_wdata & CTRL_KEEP;
      SEL_TAG: begin
        tag_d  = cfg_wdata[DATA_W-1 -: PID_W];
        mask_d = cfg_wdata[TAG_LSB +: PID_W];
        vld_d  = cfg_wdata[0];
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      lo_q   <= '0;
      hi_q   <= '0;
      ctrl_q <= '0;
      tag_q  <= '0;
      mask_q <= '0;
      vld_q  <= 1'b0;
    end else if (reg_en) begin
      lo_q   <= lo_d;
      hi_q   <= hi_d;
      ctrl_q <= ctrl_d;
      tag_q  <= tag_d;
      mask_q <= mask_d;
      vld_q  <= vld_d;
    end
  end

  always_comb begin
    unique case (rsel)
      SEL_LO:             cfg_rdata = DATA_W'(lo_q);
      SEL_HI:             cfg_rdata = DATA_W'(hi_q);
      SEL_CTRL, SEL_ALIAS: cfg_rdata = ctrl_q;
      SEL_TAG: begin
        cfg_rdata = '0;
        cfg_rdata[DATA_W-1 -: PID_W]  = tag_q;
        cfg_rdata[TAG_LSB +: PID_W]   = mask_q;
        cfg_rdata[0]                  = vld_q;
      end
      default:            cfg_rdata = '0;
    endcase
  end

endmodule

// File: rtl/mpu_rgn_perm.sv
module mpu_rgn_perm
  import mpu_rgn_pkg::*;
#(
  parameter int unsigned MID_W = 3
) (
  input  logic [DATA_W-1:0] ctrl,
  input  logic [MID_W-1:0]  master,
  output logic [PERM_W-1:0] perm,
  output logic              tag_chk_en
);

  always_comb begin
    perm       = '0;
    tag_chk_en = 1'b0;
    for (int m = 0; m < int'(NUM_FULL_M); m++) begin
      if (int'(master) == m) begin
        perm       = ctrl[PERM_W*m +: PERM_W];
        tag_chk_en = ctrl[PERM_W*m + PERM_W - 1];
      end
    end
    for (int k = 0; k < int'(NUM_RW_M); k++) begin
      if (int'(master) == int'(FIRST_RW_M) + k) begin
        perm = {{(PERM_W-2){1'b0}}, ctrl[RW_LSB + 2*k +: 2]};
      end
    end
  end

endmodule

// File: rtl/mpu_rgn_hit.sv
module mpu_rgn_hit #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned PID_W  = 8
) (
  input  logic              vld,
  input  logic [ADDR_W-1:0] lo,
  input  logic [ADDR_W-1:0] hi,
  input  logic [ADDR_W-1:0] addr,
  input  logic              tag_chk_en,
  input  logic [PID_W-1:0]  tag_in,
  input  logic [PID_W-1:0]  tag_st,
  input  logic [PID_W-1:0]  tag_mask,
  output logic              hit
);

  logic in_rng;
  logic tag_ok;

  always_comb begin
    in_rng = (addr >= lo) && (addr <= hi);
    tag_ok = ((tag_in ^ tag_st) & ~tag_mask) == '0;
    hit    = vld && in_rng && (!tag_chk_en || tag_ok);
  end

endmodule

// File: rtl/mpu_region_desc.sv
module mpu_region_desc
  import mpu_rgn_pkg::*;
#(
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned PID_W      = 8,
  parameter int unsigned MID_W      = 3,
  parameter int unsigned OFF_W      = 12,
  parameter int unsigned RGN_IDX    = 0,
  parameter int unsigned DESC_BASE  = 'h400,
  parameter int unsigned ALIAS_BASE = 'h800
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic [OFF_W-1:0]  cfg_woff,
  input  logic [31:0]       cfg_wdata,
  input  logic [OFF_W-1:0]  cfg_roff,
  output logic [31:0]       cfg_rdata,
  input  logic [MID_W-1:0]  acc_master,
  input  logic [PID_W-1:0]  acc_pid,
  input  logic [ADDR_W-1:0] acc_addr,
  output logic              acc_hit,
  output logic [5:0]        acc_perm
);

  logic              rst_sn;
  logic [ADDR_W-1:0] lo_q, hi_q;
  logic [DATA_W-1:0] ctrl_q;
  logic [PID_W-1:0]  tag_q, mask_q;
  logic              vld_q;
  logic              tag_chk_en;
  logic [PID_W-1:0]  eff_pid;

  mpu_rgn_rst_sync #(.STAGES(2)) u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .rst_sn (rst_sn)
  );

  mpu_rgn_regs #(
    .ADDR_W(ADDR_W), .PID_W(PID_W), .OFF_W(OFF_W), .RGN_IDX(RGN_IDX),
    .DESC_BASE(DESC_BASE), .ALIAS_BASE(ALIAS_BASE)
  ) u_regs (
    .clk       (clk),
    .rst_sn    (rst_sn),
    .cfg_wr    (cfg_wr),
    .cfg_woff  (cfg_woff),
    .cfg_wdata (cfg_wdata),
    .cfg_roff  (cfg_roff),
    .cfg_rdata (cfg_rdata),
    .lo_q      (lo_q),
    .hi_q      (hi_q),
    .ctrl_q    (ctrl_q),
    .tag_q     (tag_q),
    .mask_q    (mask_q),
    .vld_q     (vld_q)
  );

  mpu_rgn_perm #(.MID_W(MID_W)) u_perm (
    .ctrl       (ctrl_q),
    .master     (acc_master),
    .perm       (acc_perm),
    .tag_chk_en (tag_chk_en)
  );

  // master 0 can only carry tag zero
  assign eff_pid = (acc_master == '0) ? '0 : acc_pid;

  mpu_rgn_hit #(.ADDR_W(ADDR_W), .PID_W(PID_W)) u_hit (
    .vld        (vld_q),
    .lo         (lo_q),
    .hi         (hi_q),
    .addr       (acc_addr),
    .tag_chk_en (tag_chk_en),
    .tag_in     (eff_pid),
    .tag_st     (tag_q),
    .tag_mask   (mask_q),
    .hit        (acc_hit)
  );

endmodule

// File: rtl/mpu_rgn_chk.sv
module mpu_rgn_chk #(
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned MID_W      = 3,
  parameter int unsigned OFF_W      = 12,
  parameter int unsigned RGN_IDX    = 0,
  parameter int unsigned DESC_BASE  = 'h400,
  parameter int unsigned ALIAS_BASE = 'h800
) (
  input logic              clk,
  input logic              rst_sn,
  input logic              cfg_wr,
  input logic [OFF_W-1:0]  cfg_woff,
  input logic [31:0]       cfg_wdata,
  input logic [OFF_W-1:0]  cfg_roff,
  input logic [31:0]       cfg_rdata,
  input logic [MID_W-1:0]  acc_master,
  input logic [ADDR_W-1:0] acc_addr,
  input logic              acc_hit,
  input logic [5:0]        acc_perm,
  input logic              vld,
  input logic [ADDR_W-1:0] lo,
  input logic [ADDR_W-1:0] hi
);

  localparam logic [OFF_W-1:0] O0 = OFF_W'(DESC_BASE + 16 * RGN_IDX);
  localparam logic [OFF_W-1:0] O1 = OFF_W'(DESC_BASE + 16 * RGN_IDX + 4);
  localparam logic [OFF_W-1:0] O2 = OFF_W'(DESC_BASE + 16 * RGN_IDX + 8);
  localparam logic [OFF_W-1:0] O3 = OFF_W'(DESC_BASE + 16 * RGN_IDX + 12);
  localparam logic [OFF_W-1:0] OA = OFF_W'(ALIAS_BASE + 4 * RGN_IDX);

  logic wr_inval, wr_tag, wr_alias, rd_ctrl, rd_other;
  assign wr_inval = cfg_wr && (cfg_woff == O0 || cfg_woff == O1 || cfg_woff == O2);
  assign wr_tag   = cfg_wr && (cfg_woff == O3);
  assign wr_alias = cfg_wr && (cfg_woff == OA);
  assign rd_ctrl  = (cfg_roff == O2) || (cfg_roff == OA);
  assign rd_other = !(rd_ctrl || cfg_roff == O0 || cfg_roff == O1 || cfg_roff == O3);

  assert_bound_write_invalidates_R3: assert property (@(posedge clk) disable iff (!rst_sn)
    wr_inval |=> !vld);

  assert_tag_write_loads_valid_R4: assert property (@(posedge clk) disable iff (!rst_sn)
    wr_tag |=> (vld == $past(cfg_wdata[0])));

  assert_alias_keeps_valid_R5: assert property (@(posedge clk) disable iff (!rst_sn)
    wr_alias |=> $stable(vld));

  assert_ctrl_reserved_zero_R6: assert property (@(posedge clk) disable iff (!rst_sn)
    rd_ctrl |-> (cfg_rdata[23:18] == 6'd0 && cfg_rdata[31:30] == 2'd0));

  assert_hit_inside_bounds_R7: assert property (@(posedge clk) disable iff (!rst_sn)
    acc_hit |-> (vld && acc_addr >= lo && acc_addr <= hi));

  assert_no_field_master_R10: assert property (@(posedge clk) disable iff (!rst_sn)
    (int'(acc_master) == 3 || int'(acc_master) == 7) |-> (acc_perm == 6'd0));

  assert_unmapped_read_zero_R12: assert property (@(posedge clk) disable iff (!rst_sn)
    rd_other |-> (cfg_rdata == 32'd0));

endmodule

bind mpu_region_desc mpu_rgn_chk #(
  .ADDR_W(ADDR_W), .MID_W(MID_W), .OFF_W(OFF_W), .RGN_IDX(RGN_IDX),
  .DESC_BASE(DESC_BASE), .ALIAS_BASE(ALIAS_BASE)
) u_chk (
  .clk        (clk),
  .rst_sn     (rst_sn),
  .cfg_wr     (cfg_wr),
  .cfg_woff   (cfg_woff),
  .cfg_wdata  (cfg_wdata),
  .cfg_roff   (cfg_roff),
  .cfg_rdata  (cfg_rdata),
  .acc_master (acc_master),
  .acc_addr   (acc_addr),
  .acc_hit    (acc_hit),
  .acc_perm   (acc_perm),
  .vld        (vld_q),
  .lo         (lo_q),
  .hi         (hi_q)
);

// File: tb/mpu_region_desc_test.sv
`timescale 1ns/1ps
module mpu_region_desc_test;

  localparam int RGN = 3;
  localparam logic [11:0] W0 = 12'h430, W1 = 12'h434, W2 = 12'h438, W3 = 12'h43C;
  localparam logic [11:0] WA = 12'h80C, NEIGH = 12'h420;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr = 1'b0;
  logic [11:0] cfg_woff = '0;
  logic [31:0] cfg_wdata = '0;
  logic [11:0] cfg_roff = '0;
  logic [31:0] cfg_rdata;
  logic [2:0]  acc_master = '0;
  logic [7:0]  acc_pid = '0;
  logic [31:0] acc_addr = '0;
  logic        acc_hit;
  logic [5:0]  acc_perm;

  always #10 clk = ~clk;

  mpu_region_desc #(.RGN_IDX(RGN)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_woff(cfg_woff),
    .cfg_wdata(cfg_wdata), .cfg_roff(cfg_roff), .cfg_rdata(cfg_rdata),
    .acc_master(acc_master), .acc_pid(acc_pid), .acc_addr(acc_addr),
    .acc_hit(acc_hit), .acc_perm(acc_perm)
  );

  // behavioural reference
  logic [31:0] m_lo = 0, m_hi = 0, m_ctrl = 0;
  logic [7:0]  m_tag = 0, m_mask = 0;
  bit          m_vld = 0;
  int          n_chk = 0, n_fail = 0;
  string       tag = "R1";
  bit          done = 0;

  always @(posedge clk) begin
    if (cfg_wr) begin
      if (cfg_woff == W0) begin m_lo = cfg_wdata; m_vld = 0; end
      else if (cfg_woff == W1) begin m_hi = cfg_wdata; m_vld = 0; end
      else if (cfg_woff == W2) begin m_ctrl = cfg_wdata & 32'h3F03FFFF; m_vld = 0; end
      else if (cfg_woff == WA) m_ctrl = cfg_wdata & 32'h3F03FFFF;
      else if (cfg_woff == W3) begin
        m_tag = cfg_wdata[31:24]; m_mask = cfg_wdata[23:16]; m_vld = cfg_wdata[0];
      end
    end
  end

  function automatic logic [31:0] exp_rd(input logic [11:0] off);
    if (off == W0) return m_lo;
    if (off == W1) return m_hi;
    if (off == W2 || off == WA) return m_ctrl;
    if (off == W3) return {m_tag, m_mask, 15'd0, m_vld};
    return 32'd0;
  endfunction

  function automatic logic [5:0] exp_perm(input int m);
    if (m <= 2) return 6'((m_ctrl >> (6 * m)) & 32'h3F);
    if (m >= 4 && m <= 6) return 6'((m_ctrl >> (24 + 2 * (m - 4))) & 32'h3);
    return 6'd0;
  endfunction

  function automatic bit exp_hit(input int m, input int pid, input logic [31:0] a);
    bit en, ok;
    int who;
    if (!m_vld) return 0;
    if (a < m_lo || a > m_hi) return 0;
    en = (m <= 2) && m_ctrl[6 * m + 5];
    who = (m == 0) ? 0 : pid;
    ok = 1;
    for (int b = 0; b < 8; b++)
      if (!m_mask[b] && (((who >> b) & 1) != m_tag[b])) ok = 0;
    return !en || ok;
  endfunction

  always @(negedge clk) begin
    if (!done) begin
      logic [31:0] er;
      logic [5:0]  ep;
      bit          eh;
      er = exp_rd(cfg_roff);
      ep = exp_perm(int'(acc_master));
      eh = exp_hit(int'(acc_master), int'(acc_pid), acc_addr);
      n_chk += 3;
      if (cfg_rdata !== er) begin
        n_fail++;
        $display("FAIL %s rdata off=%h got %h exp %h", tag, cfg_roff, cfg_rdata, er);
      end
      if (acc_perm !== ep) begin
        n_fail++;
        $display("FAIL %s perm m=%0d got %h exp %h", tag, acc_master, acc_perm, ep);
      end
      if (acc_hit !== eh) begin
        n_fail++;
        $display("FAIL %s hit m=%0d pid=%h a=%h got %b exp %b", tag, acc_master, acc_pid,
                 acc_addr, acc_hit, eh);
      end
    end
  end

  task automatic wr(input logic [11:0] off, input logic [31:0] d);
    @(posedge clk); #5;
    cfg_wr = 1; cfg_woff = off; cfg_wdata = d;
    @(posedge clk); #5;
    cfg_wr = 0;
  endtask

  task automatic rd(input logic [11:0] off);
    @(posedge clk); #5;
    cfg_roff = off;
  endtask

  task automatic acc(input int m, input int pid, input logic [31:0] a);
    @(posedge clk); #5;
    acc_master = 3'(m); acc_pid = 8'(pid); acc_addr = a;
  endtask

  task automatic summary;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    // R1: reset state, all words
    tag = "R1";
    repeat (4) @(posedge clk);
    #5 rst_n = 1;
    repeat (4) @(posedge clk);
    foreach (W0[i]) ; // no-op
    rd(W0); rd(W1); rd(W2); rd(W3); rd(WA);
    acc(1, 0, 32'h0);

    // R2: bounds store full width
    tag = "R2";
    wr(W0, 32'h0000_1000); rd(W0);
    wr(W1, 32'h0000_1FFF); rd(W1);

    // R6: control word layout; reserved bits vanish
    tag = "R6";
    wr(W2, 32'hFFFF_FFFF); rd(W2);
    // R4: tag word loads tag, mask, valid
    tag = "R4";
    wr(W3, 32'h5A0F_FFFF); rd(W3);

    // R11: permission fields per master
    tag = "R11";
    wr(WA, 32'h2D00_0000 | 32'h0001_F7E5);
    for (int m = 0; m < 8; m++) acc(m, 8'h5A, 32'h1800);

    // R7: inclusive bounds, PID checks disabled
    tag = "R7";
    wr(WA, 32'h0000_0000);
    acc(1, 0, 32'h0FFF); acc(1, 0, 32'h1000); acc(1, 0, 32'h1FFF); acc(1, 0, 32'h2000);
    acc(2, 0, 32'h1234);

    // R8: masked tag compare for masters 1 and 2
    tag = "R8";
    wr(WA, 32'h0002_0800);           // enables for masters 1 and 2
    acc(1, 8'h5A, 32'h1100); acc(1, 8'h53, 32'h1100); acc(1, 8'h4A, 32'h1100);
    acc(2, 8'hDA, 32'h1100); acc(2, 8'h5F, 32'h1100);

    // R9: master 0 tag forced to zero
    tag = "R9";
    wr(W2, 32'h0000_0020); rd(W3);   // also clears valid
    acc(0, 8'h00, 32'h1100);
    wr(W3, 32'h000F_0001);           // tag 0, mask low nibble, valid
    acc(0, 8'hF0, 32'h1100); acc(0, 8'h0F, 32'h1100);
    wr(W3, 32'h8000_0001);           // stored tag 0x80, no mask: master 0 misses
    acc(0, 8'h80, 32'h1100);

    // R10: masters without an enable bit never check the tag
    tag = "R10";
    wr(W2, 32'h3F02_0820); wr(W3, 32'hAA00_0001);
    for (int m = 3; m < 8; m++) acc(m, 8'h55, 32'h1100);
    acc(1, 8'h55, 32'h1100);

    // R3: each bound/control write clears valid
    tag = "R3";
    wr(W0, 32'h0000_1000); rd(W3); acc(4, 0, 32'h1100);
    wr(W3, 32'h0000_0001); wr(W1, 32'h0000_1FFF); rd(W3);
    wr(W3, 32'h0000_0001); wr(W2, 32'h0300_0000); rd(W3);

    // R5: alias keeps valid both ways
    tag = "R5";
    wr(W3, 32'h0000_0001);
    wr(WA, 32'h0C00_0000); rd(WA); acc(5, 0, 32'h1FFF); rd(W3);
    wr(W3, 32'h0000_0000);
    wr(WA, 32'h3000_0000); rd(W3); rd(W2);

    // R12: neighbouring and unmapped offsets
    tag = "R12";
    wr(W3, 32'h0000_0001);
    wr(NEIGH, 32'h0000_0000); wr(12'h808, 32'h0000_0000); wr(12'hFFC, 32'h0);
    rd(NEIGH); rd(12'h808); rd(12'h000); rd(W3); rd(W0); rd(W2);
    acc(6, 0, 32'h1000);

    repeat (3) @(posedge clk);
    done = 1;
    summary();
    $finish;
  end

endmodule